// File: doc/BRIEF.md
# Periodic Event Pulse and Interrupt Generator

This block turns one of four periodic timing ticks from a clock counter into an event on an output that drives an open-drain pin. When the pin enable is high, the pin is pulled low. When it is low, the pin is left open. Software writes a two-bit period select, a mode bit and a mask bit through one configuration write. It reads a flag that marks events and writes that flag separately.

The block has two modes. In pulse mode, each event pulls the pin low for a fixed number of clock cycles, set by a parameter that stands for one 1/128 s period. The pin then lets go by itself, and the flag clears with it. In interrupt mode, the pin stays low until software writes 0 to the flag. Any event that arrives while the pin is held low is dropped. After reset the mask is set, so nothing is output until software clears the mask.

Top module: `periodic_event_gen`

## Requirements
- R1: After reset the pin enable and the flag are 0 and the mask is 1, so ticks produce no event until the configuration is written.
- R2: The period select picks the tick: 00 picks the 1/64 s tick, 01 the 1 s tick, 10 the 1 min tick and 11 the 1 hour tick. The other ticks have no effect.
- R3: A tick of the selected source, with the mask at 0 and the pin released, sets the flag to 1 and the pin enable to 1 on the next clock edge.
- R4: With the mode bit at 0 (pulse mode), the pin enable stays at 1 for exactly PULSE_CYCLES cycles. It then returns to 0 and the flag clears in the same edge.
- R5: With the mode bit at 1 (interrupt mode), the pin enable stays at 1 until a flag write of 0. It drops one edge after that write.
- R6: A selected tick that arrives while the pin enable is 1 is ignored. It does not lengthen a pulse, and the flag stays at 1.
- R7: While the mask is 1, no tick raises the pin enable or the flag. A configuration write with mask 1 releases the pin on the next edge and leaves the flag unchanged.
- R8: A flag write of 1 sets the readable flag to 1 and leaves the pin enable unchanged.
- R9: A flag write has priority over a selected tick in the same cycle. That tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_64hz_i | input | 1 | One-cycle 1/64 s tick |
| tick_sec_i | input | 1 | One-cycle 1 s tick |
| tick_min_i | input | 1 | One-cycle 1 min tick |
| tick_hour_i | input | 1 | One-cycle 1 hour tick |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_period_i | input | 2 | Period select to write |
| cfg_irq_mode_i | input | 1 | Mode to write: 0 pulse, 1 interrupt |
| cfg_mask_i | input | 1 | Mask to write |
| flag_we_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag value to write |
| pin_pull_o | output | 1 | Pull the pin low when 1 |
| irq_flag_o | output | 1 | Readable event flag |

## Verification
Both outputs are registers, so a wrong internal state shows at the ports one edge after the tick or write that should have acted. The faults to look for are:
- A wrong period decode makes the pin rise on a tick that was not selected.
- A wrong width count changes the number of low cycles by one or more.
- A missing busy lockout lets a second tick either restart the pulse or leave the flag in the wrong state.
- A wrong write priority lets an event survive a flag clear made in the same cycle.

// File: rtl/periodic_event_pkg.sv
package periodic_event_pkg;
  typedef enum logic [1:0] {
    PER_64HZ = 2'b00,
    PER_SEC  = 2'b01,
    PER_MIN  = 2'b10,
    PER_HOUR = 2'b11
  } period_e;

  typedef enum logic {
    MODE_PULSE = 1'b0,
    MODE_IRQ   = 1'b1
  } mode_e;

  localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/tick_select.sv
module tick_select
  import periodic_event_pkg::*;
(
  input  logic [NUM_SRC-1:0] ticks_i,
  input  period_e            sel_i,
  output logic               hit_o
);
  logic [NUM_SRC-1:0] dec;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
    assign dec[g] = (sel_i == period_e'(g)) && ticks_i[g];
  end

  assign hit_o = |dec;
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
  parameter int unsigned WIDTH_CYC = 16,
  localparam int unsigned CW = (WIDTH_CYC > 1) ? $clog2(WIDTH_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clear_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (clear_i) begin
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(WIDTH_CYC - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/periodic_event_gen.sv
module periodic_event_gen
  import periodic_event_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_64hz_i,
  input  logic       tick_sec_i,
  input  logic       tick_min_i,
  input  logic       tick_hour_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_period_i,
  input  logic       cfg_irq_mode_i,
  input  logic       cfg_mask_i,
  input  logic       flag_we_i,
  input  logic       flag_wdata_i,
  output logic       pin_pull_o,
  output logic       irq_flag_o
);
  period_e period_q;
  mode_e   mode_q;
  logic    mask_q;
  logic    pin_q;
  logic    flag_q;
  logic    hit;
  logic    event_w;
  logic    expire;
  logic    force_off;
  logic    pulse_end;

  tick_select u_sel (
    .ticks_i ({tick_hour_i, tick_min_i, tick_sec_i, tick_64hz_i}),
    .sel_i   (period_q),
    .hit_o   (hit)
  );

  // flag write wins over a same-cycle tick; busy pin drops new events
  assign event_w   = hit && !mask_q && !pin_q && !flag_we_i;
  assign force_off = (cfg_we_i && cfg_mask_i) || (flag_we_i && !flag_wdata_i);
  assign pulse_end = expire && (mode_q == MODE_PULSE);

  pulse_width_timer #(.WIDTH_CYC(PULSE_CYCLES)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (event_w),
    .clear_i  (force_off),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= PER_64HZ;
      mode_q   <= MODE_PULSE;
      mask_q   <= 1'b1;
    end else if (cfg_we_i) begin
      period_q <= period_e'(cfg_period_i);
      mode_q   <= mode_e'(cfg_irq_mode_i);
      mask_q   <= cfg_mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pin_q <= 1'b0;
    else if (force_off) pin_q <= 1'b0;
    else if (event_w)   pin_q <= 1'b1;
    else if (pulse_end) pin_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (flag_we_i)          flag_q <= flag_wdata_i;
    else if (event_w)            flag_q <= 1'b1;
    else if (pulse_end && pin_q) flag_q <= 1'b0;
  end

  assign pin_pull_o = pin_q;
  assign irq_flag_o = flag_q;
endmodule

// File: rtl/periodic_event_chk.sv
module periodic_event_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hit,
  input logic mask_q,
  input logic mode_q,
  input logic cfg_we_i,
  input logic flag_we_i,
  input logic flag_wdata_i,
  input logic pin_pull_o,
  input logic irq_flag_o
);
  // R7
  mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |-> !pin_pull_o);

  // R3
  event_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !mask_q && !pin_pull_o && !flag_we_i && !cfg_we_i |=> pin_pull_o && irq_flag_o);

  // R5
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q && pin_pull_o && !cfg_we_i && !(flag_we_i && !flag_wdata_i) |=> pin_pull_o);

  // R4
  release_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_pull_o) && !mask_q && !$past(flag_we_i) |-> !irq_flag_o);

  // R8
  flag_set_no_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && flag_wdata_i && !pin_pull_o && !cfg_we_i |=> !pin_pull_o && irq_flag_o);
endmodule

bind periodic_event_gen periodic_event_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hit          (hit),
  .mask_q       (mask_q),
  .mode_q       (mode_q),
  .cfg_we_i     (cfg_we_i),
  .flag_we_i    (flag_we_i),
  .flag_wdata_i (flag_wdata_i),
  .pin_pull_o   (pin_pull_o),
  .irq_flag_o   (irq_flag_o)
);

// File: tb/periodic_event_gen_tb_top.sv
module periodic_event_gen_tb_top;
  localparam int W = 16;
  // {period[1:0], src[1:0], mask, expect}
  localparam int NV = 10;
  localparam logic [5:0] VEC [NV] = '{
    6'b00_00_0_1, 6'b00_01_0_0, 6'b01_01_0_1, 6'b01_10_0_0, 6'b10_10_0_1,
    6'b10_11_0_0, 6'b11_11_0_1, 6'b11_00_0_0, 6'b01_01_1_0, 6'b11_11_1_0
  };

  logic clk = 0, rst_n = 0;
  logic [3:0] ticks = '0;
  logic cfg_we = 0, cfg_mode = 0, cfg_mask = 0, flag_we = 0, flag_wd = 0;
  logic [1:0] cfg_per = '0;
  logic pin, flag;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  periodic_event_gen #(.PULSE_CYCLES(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tick_64hz_i(ticks[0]), .tick_sec_i(ticks[1]), .tick_min_i(ticks[2]), .tick_hour_i(ticks[3]),
    .cfg_we_i(cfg_we), .cfg_period_i(cfg_per), .cfg_irq_mode_i(cfg_mode), .cfg_mask_i(cfg_mask),
    .flag_we_i(flag_we), .flag_wdata_i(flag_wd),
    .pin_pull_o(pin), .irq_flag_o(flag)
  );

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pin/flag actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] p, logic m, logic k);
    @(negedge clk); cfg_we = 1; cfg_per = p; cfg_mode = m; cfg_mask = k;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic tick(int s);
    @(negedge clk); ticks[s] = 1;
    @(negedge clk); ticks = '0;
  endtask

  task automatic fwr(logic d);
    @(negedge clk); flag_we = 1; flag_wd = d;
    @(negedge clk); flag_we = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset", {pin, flag}, 2'b00);
    tick(0);
    chk("R1 masked after reset", {pin, flag}, 2'b00);

    // R2, R3, R7 table
    foreach (VEC[i]) begin
      cfg(VEC[i][5:4], 1'b1, VEC[i][1]);
      tick(int'(VEC[i][3:2]));
      chk("R2/R3/R7 vector", {pin, flag}, {VEC[i][0], VEC[i][0]});
      fwr(1'b0);
    end

    // R4 pulse width and self release
    cfg(2'b00, 1'b0, 1'b0);
    tick(0);
    n = 0;
    while (pin && n < 100) begin n++; @(negedge clk); end
    checks++;
    if (n != W) begin errors++; $display("FAIL R4 width actual %0d expected %0d", n, W); end
    chk("R4 flag cleared with pin", {pin, flag}, 2'b00);

    // R6 tick during pulse does not extend it
    tick(0);
    repeat (4) @(negedge clk);
    tick(0);
    chk("R6 flag stays during pulse", {pin, flag}, 2'b11);
    n = 6;
    while (pin && n < 100) begin n++; @(negedge clk); end
    checks++;
    if (n != W) begin errors++; $display("FAIL R6 width actual %0d expected %0d", n, W); end

    // R5 interrupt hold, R6 ignored events
    cfg(2'b01, 1'b1, 1'b0);
    tick(1);
    repeat (W + 5) @(negedge clk);
    chk("R5 held low", {pin, flag}, 2'b11);
    tick(1);
    chk("R6 ignored while held", {pin, flag}, 2'b11);
    fwr(1'b0);
    chk("R5 release on flag clear", {pin, flag}, 2'b00);

    // R8 flag write 1 leaves pin
    fwr(1'b1);
    chk("R8 flag set, pin idle", {pin, flag}, 2'b01);
    tick(1);
    chk("R8 event still accepted", {pin, flag}, 2'b11);

    // R7 mask write releases pin, keeps flag
    cfg(2'b01, 1'b1, 1'b1);
    chk("R7 mask release", {pin, flag}, 2'b01);
    fwr(1'b0);

    // R9 flag write and tick same cycle
    cfg(2'b10, 1'b1, 1'b0);
    @(negedge clk); ticks[2] = 1; flag_we = 1; flag_wd = 0;
    @(negedge clk); ticks = '0; flag_we = 0;
    chk("R9 write wins", {pin, flag}, 2'b00);

    // R1 asynchronous reset mid-event
    tick(2);
    #1 rst_n = 0;
    #1 chk("R1 async reset", {pin, flag}, 2'b00);
    @(negedge clk); rst_n = 1;
    tick(2);
    chk("R1 mask back after reset", {pin, flag}, 2'b00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule